// File: doc/BRIEF.md
# Watchdog Timer with Two-Write Feed Sequence

This block is a memory-mapped watchdog timer. Software starts it by setting a sticky enable bit. It then keeps the watchdog alive by writing two fixed values in a row to a feed register. Each correct pair reloads a down-counter from a programmable constant. The counter steps once every four strobes of a prescaled watchdog tick input.

A timeout occurs in two cases: the counter runs out, or a feed write breaks the sequence. On a timeout the block raises a software-clearable timeout flag and a sticky interrupt flag. If reset-on-timeout has been selected, it also pulses a system reset request for one clock. Once enabled, the watchdog can only be stopped by the module reset.

Two small state machines do the work. The feed checker has two states. It sits in FEED_IDLE until it sees the first value, then moves to FEED_ARMED. From FEED_ARMED it returns to FEED_IDLE on any next feed write, which is valid only if it carries the second value, or on a write to any other address, which counts as a wrong feed. The counter also has two states. It stays in CNT_HALT, where the value register mirrors the constant, until the first valid feed while enabled. It then moves to CNT_RUN and stays there until the module is reset.

Top module: `wdt_feed_guard`

## Requirements
- R1: After module reset, the mode register (offset 0x0) reads 0 and the constant register (offset 0x4) reads 0xFF. The value register (offset 0xC) reads 0xFF, the feed register (offset 0x8) reads 0, and irq and rst_req are low.
- R2: A constant write below 0xFF stores 0xFF; other values are stored as written. Before the first valid feed, the value register reads the current constant. Writes to the value register change nothing.
- R3: The counter starts only on the first valid feed while enabled. A valid feed is a 32-bit write of 0xAA to offset 0x8, with the very next bus write being 0x55 to offset 0x8. Once started, the value register loads the constant and then drops by one on every fourth cycle in which wd_tick is high.
- R4: When the counter is at 0 and a fourth tick arrives, that is a timeout: (constant+1)*4 ticks after a feed. A timeout sets mode bit 2 (timeout flag) and mode bit 3 (interrupt flag), and the counter reloads the constant and keeps running.
- R5: While enabled, any of the following counts as a wrong feed and gives an immediate timeout, with the same effects as R4: a feed write that is not 0xAA when no sequence is open; a feed write other than 0x55 right after 0xAA; or a write to any other offset right after 0xAA. The counter also reloads.
- R6: rst_req goes high for the cycle after each timeout, but only if mode bit 1 (reset-on-timeout) was already set when the timeout occurred.
- R7: irq follows mode bit 3, which no write can clear. Writing the mode register with bit 2 = 0 clears the timeout flag. Writing it with bit 2 = 1 leaves the flag unchanged.
- R8: Mode bit 0 (enable) and bit 1 (reset-on-timeout) are set by writing 1 and are not cleared by writing 0. Only module reset clears them.
- R9: A valid feed while running reloads the counter and restarts the divide-by-four phase. A timeout is suppressed if it would fall in the same cycle as a valid feed.
- R10: While the enable bit is 0, feed writes have no effect: no start and no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous module reset |
| wd_tick | input | 1 | Prescaled watchdog tick strobe, one clock wide |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt level, follows the interrupt flag |
| rst_req | output | 1 | System reset request pulse |

## Verification
Read data is combinational from the address and the register state. A write therefore shows on the read port from the falling edge after the rising edge that captured it. The timeout flag, interrupt flag and rst_req all change on the same rising edge as the feed write or tick that causes the timeout. The counter value changes on the edge of the fourth counted tick.

The bench drives every input on the falling edge and samples 1 ns later. A behavioural model is updated on each rising edge from the inputs held there, and the directed checks use tick-counting tasks. As a result, each expected value is compared in the first sampling window after the edge that produces it.

// File: rtl/wdt_feed_pkg.sv
package wdt_feed_pkg;

    // Register byte offsets; software depends on these.
    localparam int OFF_MODE  = 'h0;
    localparam int OFF_CONST = 'h4;
    localparam int OFF_FEED  = 'h8;
    localparam int OFF_VALUE = 'hC;

    // Mode register bit positions.
    localparam int BIT_EN   = 0;
    localparam int BIT_RST  = 1;
    localparam int BIT_TOF  = 2;
    localparam int BIT_INTF = 3;

    // Feed sequence codes.
    localparam int FEED_FIRST  = 'hAA;
    localparam int FEED_SECOND = 'h55;

    typedef enum logic {
        FEED_IDLE,
        FEED_ARMED
    } feed_state_t;

    typedef enum logic {
        CNT_HALT,
        CNT_RUN
    } cnt_state_t;

endpackage

// File: rtl/wdt_feed_fsm.sv
module wdt_feed_fsm
    import wdt_feed_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_feed,
    input  logic              wr_other,
    input  logic [DATA_W-1:0] wdata,
    output logic              feed_ok,
    output logic              feed_bad
);

    localparam logic [DATA_W-1:0] CODE_A = DATA_W'(FEED_FIRST);
    localparam logic [DATA_W-1:0] CODE_B = DATA_W'(FEED_SECOND);

    feed_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FEED_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d     = st_q;
        feed_ok  = 1'b0;
        feed_bad = 1'b0;
        if (enable) begin
            unique case (st_q)
                FEED_IDLE: begin
                    if (wr_feed) begin
                        if (wdata == CODE_A) st_d = FEED_ARMED;
                        else                 feed_bad = 1'b1;
                    end
                end
                FEED_ARMED: begin
                    if (wr_feed) begin
                        st_d = FEED_IDLE;
                        if (wdata == CODE_B) feed_ok  = 1'b1;
                        else                 feed_bad = 1'b1;
                    end else if (wr_other) begin
                        st_d     = FEED_IDLE;
                        feed_bad = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
    import wdt_feed_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] value,
    output logic             running,
    output logic             underflow
);

    localparam int             PS_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    cnt_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PS_W-1:0]  ps_q, ps_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CNT_HALT;
            cnt_q <= '0;
            ps_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ps_q  <= ps_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        ps_d  = ps_q;
        unique case (st_q)
            CNT_HALT: begin
                if (start) begin
                    st_d  = CNT_RUN;
                    cnt_d = reload_val;
                    ps_d  = '0;
                end
            end
            CNT_RUN: begin
                if (start || restart) begin
                    cnt_d = reload_val;
                    ps_d  = '0;
                end else if (tick) begin
                    if (ps_q == PS_LAST) begin
                        ps_d  = '0;
                        cnt_d = (cnt_q == '0) ? reload_val : cnt_q - 1'b1;
                    end else begin
                        ps_d = ps_q + 1'b1;
                    end
                end
            end
        endcase
    end

    always_comb begin
        running   = (st_q == CNT_RUN);
        underflow = running && tick && (ps_q == PS_LAST) && (cnt_q == '0);
        value     = running ? cnt_q : reload_val;
    end

endmodule

// File: rtl/wdt_feed_guard.sv
module wdt_feed_guard
    import wdt_feed_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int PRESCALE = 4,
    parameter int TC_MIN   = 'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFF_MODE);
    localparam logic [ADDR_W-1:0] A_CONST = ADDR_W'(OFF_CONST);
    localparam logic [ADDR_W-1:0] A_FEED  = ADDR_W'(OFF_FEED);
    localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(OFF_VALUE);
    localparam logic [DATA_W-1:0] TC_FLOOR = DATA_W'(TC_MIN);

    logic              wr_mode, wr_const, wr_feed, wr_other;
    logic              en_q, rm_q, tof_q, intf_q;
    logic [DATA_W-1:0] tc_q;
    logic              feed_ok, feed_bad;
    logic [DATA_W-1:0] cnt_value;
    logic              cnt_running, cnt_underflow;
    logic              timeout;

    always_comb begin
        wr_mode  = bus_we && (bus_addr == A_MODE);
        wr_const = bus_we && (bus_addr == A_CONST);
        wr_feed  = bus_we && (bus_addr == A_FEED);
        wr_other = bus_we && (bus_addr != A_FEED);
    end

    wdt_feed_fsm #(.DATA_W(DATA_W)) u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (en_q),
        .wr_feed  (wr_feed),
        .wr_other (wr_other),
        .wdata    (bus_wdata),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad)
    );

    wdt_down_counter #(.CNT_W(DATA_W), .PRESCALE(PRESCALE)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (wd_tick),
        .start      (feed_ok),
        .restart    (feed_bad),
        .reload_val (tc_q),
        .value      (cnt_value),
        .running    (cnt_running),
        .underflow  (cnt_underflow)
    );

    // A valid feed in the same cycle wins over a pending underflow.
    assign timeout = feed_bad || (cnt_underflow && !feed_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rm_q    <= 1'b0;
            tof_q   <= 1'b0;
            intf_q  <= 1'b0;
            tc_q    <= TC_FLOOR;
            rst_req <= 1'b0;
        end else begin
            if (wr_mode) begin
                en_q <= en_q | bus_wdata[BIT_EN];
                rm_q <= rm_q | bus_wdata[BIT_RST];
            end
            tof_q   <= (wr_mode ? (tof_q & bus_wdata[BIT_TOF]) : tof_q) | timeout;
            intf_q  <= intf_q | timeout;
            rst_req <= timeout & rm_q;
            if (wr_const) tc_q <= (bus_wdata < TC_FLOOR) ? TC_FLOOR : bus_wdata;
        end
    end

    assign irq = intf_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE: begin
                bus_rdata[BIT_EN]   = en_q;
                bus_rdata[BIT_RST]  = rm_q;
                bus_rdata[BIT_TOF]  = tof_q;
                bus_rdata[BIT_INTF] = intf_q;
            end
            A_CONST: bus_rdata = tc_q;
            A_VALUE: bus_rdata = cnt_value;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_feed_guard_chk.sv
module wdt_feed_guard_chk #(
    parameter int DATA_W = 32,
    parameter int TC_MIN = 'hFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              rst_req,
    input logic              en_q,
    input logic              rm_q,
    input logic              timeout,
    input logic [DATA_W-1:0] tc_q
);

    localparam logic [DATA_W-1:0] TC_FLOOR = DATA_W'(TC_MIN);

    // R8
    en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) en_q |=> en_q);

    // R8
    rm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) rm_q |=> rm_q);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> irq);

    // R5
    timeout_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) timeout |=> irq);

    // R6
    rst_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> rm_q);

    // R4
    rst_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> irq);

    // R2
    tc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n) tc_q >= TC_FLOOR);

endmodule

bind wdt_feed_guard wdt_feed_guard_chk #(.DATA_W(DATA_W), .TC_MIN(TC_MIN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .rst_req (rst_req),
    .en_q    (en_q),
    .rm_q    (rm_q),
    .timeout (timeout),
    .tc_q    (tc_q)
);

// File: tb/sim_wdt_feed_guard.sv
`timescale 1ns/100ps
module sim_wdt_feed_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wd_tick = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_on   = 1'b0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    wdt_feed_guard u0 (
        .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    // Behavioural reference model
    bit          m_en, m_rm, m_tof, m_int, m_run, m_armed, m_rst;
    logic [31:0] m_const, m_cnt;
    int          m_ps;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_rm = 0; m_tof = 0; m_int = 0; m_run = 0;
            m_armed = 0; m_rst = 0; m_const = 32'hFF; m_cnt = 0; m_ps = 0;
        end else begin
            bit good, bad, under, tmo, old_rm;
            logic [31:0] old_const;
            good = 0; bad = 0;
            old_rm = m_rm;
            old_const = m_const;
            if (m_en) begin
                if (m_armed) begin
                    if (bus_we) begin
                        m_armed = 0;
                        if (bus_addr == 4'h8 && bus_wdata == 32'h55) good = 1;
                        else bad = 1;
                    end
                end else if (bus_we && bus_addr == 4'h8) begin
                    if (bus_wdata == 32'hAA) m_armed = 1;
                    else bad = 1;
                end
            end
            under = m_run && wd_tick && m_ps == 3 && m_cnt == 0;
            tmo = bad || (under && !good);
            if (good) begin
                m_run = 1; m_cnt = old_const; m_ps = 0;
            end else if (bad) begin
                m_cnt = old_const; m_ps = 0;
            end else if (m_run && wd_tick) begin
                if (m_ps == 3) begin
                    m_ps = 0;
                    m_cnt = (m_cnt == 0) ? old_const : m_cnt - 1;
                end else m_ps = m_ps + 1;
            end
            if (bus_we && bus_addr == 4'h0) begin
                m_en  = m_en | bus_wdata[0];
                m_rm  = m_rm | bus_wdata[1];
                m_tof = m_tof & bus_wdata[2];
            end
            if (bus_we && bus_addr == 4'h4)
                m_const = (bus_wdata < 32'hFF) ? 32'hFF : bus_wdata;
            m_tof = m_tof | tmo;
            m_int = m_int | tmo;
            m_rst = tmo & old_rm;
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'h0: return {28'h0, m_int, m_tof, m_rm, m_en};
            4'h4: return m_const;
            4'hC: return m_run ? m_cnt : m_const;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            #1;
            check("R7 model irq", {31'h0, irq}, {31'h0, m_int});
            check("R6 model rst_req", {31'h0, rst_req}, {31'h0, m_rst});
            check("R3 model rdata", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        wd_tick = 1;
        repeat (n) @(negedge clk);
        wd_tick = 0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        mon_on = 1;
        // R1 reset state
        rd("R1 mode", 4'h0, 32'h0);
        rd("R1 const", 4'h4, 32'hFF);
        rd("R1 value", 4'hC, 32'hFF);
        rd("R1 feed", 4'h8, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 rst_req", {31'h0, rst_req}, 32'h0);

        // R2 floor, mirror, value write ignored
        wr(4'h4, 32'h10);   rd("R2 floor", 4'h4, 32'hFF);
        wr(4'h4, 32'h300);  rd("R2 const", 4'h4, 32'h300);
        rd("R2 mirror", 4'hC, 32'h300);
        wr(4'hC, 32'h5);    rd("R2 value ignored", 4'hC, 32'h300);

        // R10 disabled feeds
        wr(4'h8, 32'hAA); wr(4'h8, 32'h55); ticks(20);
        rd("R10 no start", 4'hC, 32'h300);
        wr(4'h8, 32'h12);
        rd("R10 no timeout", 4'h0, 32'h0);
        check("R10 irq", {31'h0, irq}, 32'h0);

        // R3 enable without feed
        wr(4'h0, 32'h1); rd("R8 enable set", 4'h0, 32'h1);
        ticks(10); rd("R3 halted", 4'hC, 32'h300);

        // R3 start and count
        wr(4'h4, 32'h100);
        wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
        rd("R3 loaded", 4'hC, 32'h100);
        ticks(8); rd("R3 two steps", 4'hC, 32'hFE);
        ticks(3);
        // R9 refeed reloads and restarts phase
        wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
        rd("R9 reload", 4'hC, 32'h100);
        ticks(4); rd("R9 phase", 4'hC, 32'hFF);

        // R4 underflow timing
        ticks(1023);
        rd("R4 at zero", 4'hC, 32'h0);
        check("R4 no irq yet", {31'h0, irq}, 32'h0);
        ticks(1);
        check("R4 irq", {31'h0, irq}, 32'h1);
        check("R6 no rst without mode", {31'h0, rst_req}, 32'h0);
        rd("R4 flags", 4'h0, 32'hD);
        rd("R4 reload", 4'hC, 32'h100);

        // R7 / R8
        wr(4'h0, 32'h0); rd("R7 tof clear, R8 en kept", 4'h0, 32'h9);
        wr(4'h0, 32'h4); rd("R7 tof not set by write", 4'h0, 32'h9);
        check("R7 irq stays", {31'h0, irq}, 32'h1);

        // R5 aborted by other-register write, R6 pulse
        wr(4'h0, 32'h2); rd("R8 rst mode set", 4'h0, 32'hB);
        wr(4'h8, 32'hAA); wr(4'h4, 32'h200);
        check("R5 abort rst_req", {31'h0, rst_req}, 32'h1);
        rd("R5 abort flags", 4'h0, 32'hF);
        @(negedge clk);
        check("R6 single pulse", {31'h0, rst_req}, 32'h0);

        wr(4'h0, 32'h0);
        wr(4'h8, 32'h33);
        check("R5 bad first", {31'h0, rst_req}, 32'h1);
        rd("R5 bad first flags", 4'h0, 32'hF);

        wr(4'h0, 32'h0);
        wr(4'h8, 32'hAA); wr(4'h8, 32'h77);
        check("R5 bad second", {31'h0, rst_req}, 32'h1);

        wr(4'h0, 32'h0);
        wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
        check("R9 good feed no rst", {31'h0, rst_req}, 32'h0);
        rd("R9 good feed flags", 4'h0, 32'hB);

        // R6 underflow with reset mode
        wr(4'h4, 32'hFF);
        wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
        ticks(1023);
        check("R6 before underflow", {31'h0, rst_req}, 32'h0);
        ticks(1);
        check("R6 underflow rst_req", {31'h0, rst_req}, 32'h1);
        @(negedge clk);
        check("R6 pulse ends", {31'h0, rst_req}, 32'h0);

        // Mixed random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            wd_tick = 1'($urandom_range(0, 1));
            bus_addr = 4'($urandom_range(0, 3) * 4);
            bus_we = ($urandom_range(0, 7) == 0);
            case ($urandom_range(0, 3))
                0: bus_wdata = 32'hAA;
                1: bus_wdata = 32'h55;
                2: bus_wdata = 32'($urandom_range(0, 'h140));
                default: bus_wdata = $urandom;
            endcase
        end
        @(negedge clk);
        bus_we = 0; wd_tick = 0;

        // R1 / R8 only module reset clears
        do_reset();
        rd("R8 reset clears", 4'h0, 32'h0);
        rd("R1 const after reset", 4'h4, 32'hFF);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);

        repeat (4) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule